// File: doc/BRIEF.md
# Oversampling Averaging Conversion Controller

This block runs a multichannel sampling converter core through a burst of acquisitions and turns the burst into one averaged result per channel. A software-independent 3-bit ratio code selects how many acquisitions form one result: 1, 2, 4, 8, 16, 32 or 64. An external convert-start edge begins each burst. The first acquisition follows that edge at once. Every further acquisition is paced by an internal gap timer.

The converter core sits behind a plain handshake. The block raises a one-cycle sample request. The core answers later with a sample-valid pulse that carries one signed 16-bit word per channel. Each channel keeps a signed running sum. At the end of the burst the sum is divided by the ratio and the result is stored in an output register.

A busy output covers the whole burst. The output registers change only on the edge where busy falls, so a host can read the previous result while the next burst runs. The ratio code is captured on that same falling edge and governs the following burst.

Top module: `osavg_ctrl`

## Requirements
- R1: After reset, `busy_o`, `smp_req_o` and `cfg_err_o` are 0, and `res_o` is all zeros. The ratio used for the first burst is 1.
- R2: A burst starts only on a low-to-high transition of the AND of `cnv_a_i` and `cnv_b_i`. One input going high alone does not start a burst. In the cycle after the edge is sampled, `busy_o` and `smp_req_o` are both 1.
- R3: `smp_req_o` lasts one cycle. No new request is raised until `smp_vld_i` has answered the previous one. After an accepted `smp_vld_i`, with G on `gap_cycles_i`, `smp_req_o` stays low for exactly G+1 cycles and then the next request is raised.
- R4: The number of requests in a burst is the ratio N. Codes 000 to 110 give N = 2^code, so 000→1, 001→2, 010→4, 011→8, 100→16, 101→32 and 110→64.
- R5: `ratio_sel_i` is sampled only on the clock edge where `busy_o` falls, and that value governs the next burst. The code present at the start of a burst, or during it, has no effect on that burst.
- R6: Channel c of `res_o` is bits [16c+15:16c]. Its value is floor(sum of the N signed samples of channel c / N), in 16-bit two's complement. This result is exact even for 64 samples of -32768 or 64 samples of 32767.
- R7: While `busy_o` is 1, `res_o` holds its previous value. It takes the new averages on the same edge where `busy_o` falls.
- R8: `busy_o` is high from the cycle after the start edge until the burst ends. It falls one cycle after the last `smp_vld_i` is accepted. `smp_req_o` is never high while `busy_o` is low.
- R9: Code 111 is treated as ratio 1. Capturing code 111 sets `cfg_err_o`, and `cfg_err_o` stays 1 until reset.
- R10: Convert-start edges that arrive while `busy_o` is high are dropped. They are not queued, and no burst follows once the current burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnv_a_i | input | 1 | Convert-start, first input (driven together with `cnv_b_i`) |
| cnv_b_i | input | 1 | Convert-start, second input |
| ratio_sel_i | input | 3 | Oversampling ratio code for the next burst |
| gap_cycles_i | input | GAP_W (8) | Idle cycles between an accepted sample and the next request, minus one |
| smp_req_o | output | 1 | One-cycle acquisition request to the converter core |
| smp_vld_i | input | 1 | Converter core answer: `smp_data_i` holds one sample per channel |
| smp_data_i | input | NCH*DW (64) | Signed samples, channel c in bits [16c+15:16c] |
| busy_o | output | 1 | High for the whole burst |
| res_o | output | NCH*DW (64) | Averaged results, channel c in bits [16c+15:16c] |
| cfg_err_o | output | 1 | Sticky flag: invalid ratio code was captured |

## Verification
The bench sets the ratio code to a decoy value at each start edge and writes the real code during the burst. A design that samples the code at the start would therefore issue the wrong number of requests. Bursts of 64 samples at full-scale negative and full-scale positive values expose an accumulator that is too narrow: it wraps and returns a result with the wrong sign. Pseudo-random negative sums check the rounding toward negative infinity, which a design that divides by truncation gets wrong by one LSB. A second start edge during a burst, a lone convert-start input, and the invalid code each check that the design does not start a spurious burst or lose the sticky error flag.

// File: rtl/osavg_pkg.sv
package osavg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_GAP,
        ST_DONE
    } osavg_st_e;

    localparam int unsigned SEL_W = 3;

    // Ratio code to divide shift; the invalid code maps to ratio 1.
    function automatic logic [SEL_W-1:0] code_to_shift(input logic [SEL_W-1:0] code);
        return (code == 3'b111) ? 3'd0 : code;
    endfunction

endpackage

// File: rtl/osavg_edge_det.sv
module osavg_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic a_i,
    input  logic b_i,
    output logic rise_o
);
    logic both;
    logic lvl_d, lvl_q;

    always_comb begin
        both   = a_i & b_i;
        lvl_d  = both;
        rise_o = both & ~lvl_q;
    end

    // Reset to 1: an input already high at reset release is not an edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) lvl_q <= 1'b1;
        else         lvl_q <= lvl_d;
    end
endmodule

// File: rtl/osavg_seq.sv
module osavg_seq
    import osavg_pkg::*;
#(
    parameter int unsigned GAP_W     = 8,
    parameter int unsigned MAX_SHIFT = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             vld_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             req_o,
    output logic             busy_o,
    output logic             acc_clr_o,
    output logic             acc_en_o,
    output logic             load_o,
    output logic [SEL_W-1:0] shift_o,
    output logic             err_o
);
    localparam int unsigned CNT_W = MAX_SHIFT + 1;

    typedef struct packed {
        osavg_st_e        st;
        logic             busy;
        logic             req;
        logic [GAP_W-1:0] gap;
        logic [CNT_W-1:0] taken;
        logic [SEL_W-1:0] shift;
        logic             err;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] ratio_n;
    logic [CNT_W-1:0] taken_nx;

    always_comb begin
        seq_d     = seq_q;
        seq_d.req = 1'b0;
        acc_clr_o = 1'b0;
        acc_en_o  = 1'b0;
        load_o    = 1'b0;
        ratio_n   = CNT_W'(1) << seq_q.shift;
        taken_nx  = seq_q.taken + CNT_W'(1);

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_ACQ;
                    seq_d.busy  = 1'b1;
                    seq_d.req   = 1'b1;
                    seq_d.taken = '0;
                    acc_clr_o   = 1'b1;
                end
            end
            ST_ACQ: begin
                if (vld_i) begin
                    acc_en_o    = 1'b1;
                    seq_d.taken = taken_nx;
                    if (taken_nx == ratio_n) begin
                        seq_d.st = ST_DONE;
                    end else begin
                        seq_d.st  = ST_GAP;
                        seq_d.gap = gap_i;
                    end
                end
            end
            ST_GAP: begin
                if (seq_q.gap == '0) begin
                    seq_d.req = 1'b1;
                    seq_d.st  = ST_ACQ;
                end else begin
                    seq_d.gap = seq_q.gap - GAP_W'(1);
                end
            end
            ST_DONE: begin
                load_o      = 1'b1;
                seq_d.busy  = 1'b0;
                seq_d.st    = ST_IDLE;
                seq_d.shift = code_to_shift(sel_i);
                if (sel_i == 3'b111) seq_d.err = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.st    <= ST_IDLE;
            seq_q.busy  <= 1'b0;
            seq_q.req   <= 1'b0;
            seq_q.gap   <= '0;
            seq_q.taken <= '0;
            seq_q.shift <= '0;
            seq_q.err   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_o   = seq_q.req;
    assign busy_o  = seq_q.busy;
    assign shift_o = seq_q.shift;
    assign err_o   = seq_q.err;
endmodule

// File: rtl/osavg_lane.sv
module osavg_lane
    import osavg_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned ACC_W = 22
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [SEL_W-1:0] shift_i,
    input  logic [DW-1:0]    smp_i,
    output logic [DW-1:0]    res_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [DW-1:0]    res;
    } lane_t;

    lane_t                   lane_d, lane_q;
    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] avg_s;
    logic        [ACC_W-1:0] smp_ext;

    always_comb begin
        lane_d  = lane_q;
        smp_ext = {{(ACC_W-DW){smp_i[DW-1]}}, smp_i};
        acc_s   = lane_q.acc;
        avg_s   = acc_s >>> shift_i;
        if (clr_i)     lane_d.acc = '0;
        else if (en_i) lane_d.acc = lane_q.acc + smp_ext;
        if (load_i)    lane_d.res = avg_s[DW-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lane_q.acc <= '0;
            lane_q.res <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign res_o = lane_q.res;
endmodule

// File: rtl/osavg_ctrl.sv
module osavg_ctrl
    import osavg_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned DW        = 16,
    parameter int unsigned GAP_W     = 8,
    parameter int unsigned MAX_SHIFT = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cnv_a_i,
    input  logic              cnv_b_i,
    input  logic [2:0]        ratio_sel_i,
    input  logic [GAP_W-1:0]  gap_cycles_i,
    output logic              smp_req_o,
    input  logic              smp_vld_i,
    input  logic [NCH*DW-1:0] smp_data_i,
    output logic              busy_o,
    output logic [NCH*DW-1:0] res_o,
    output logic              cfg_err_o
);
    localparam int unsigned ACC_W = DW + MAX_SHIFT;

    logic             start;
    logic             acc_clr, acc_en, load;
    logic [SEL_W-1:0] shift;

    osavg_edge_det i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (cnv_a_i),
        .b_i    (cnv_b_i),
        .rise_o (start)
    );

    osavg_seq #(
        .GAP_W     (GAP_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) i_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .vld_i     (smp_vld_i),
        .gap_i     (gap_cycles_i),
        .sel_i     (ratio_sel_i),
        .req_o     (smp_req_o),
        .busy_o    (busy_o),
        .acc_clr_o (acc_clr),
        .acc_en_o  (acc_en),
        .load_o    (load),
        .shift_o   (shift),
        .err_o     (cfg_err_o)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        osavg_lane #(
            .DW    (DW),
            .ACC_W (ACC_W)
        ) i_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (acc_clr),
            .en_i    (acc_en),
            .load_i  (load),
            .shift_i (shift),
            .smp_i   (smp_data_i[ch*DW +: DW]),
            .res_o   (res_o[ch*DW +: DW])
        );
    end
endmodule

// File: rtl/osavg_chk.sv
module osavg_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              smp_req_o,
    input logic              smp_vld_i,
    input logic              busy_o,
    input logic [NCH*DW-1:0] res_o,
    input logic              cfg_err_o
);
    logic pending;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)        pending <= 1'b0;
        else if (smp_req_o) pending <= 1'b1;
        else if (smp_vld_i) pending <= 1'b0;
    end

    assert_req_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_req_o |=> !smp_req_o);

    assert_req_after_vld_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_req_o |-> !pending);

    assert_start_with_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> smp_req_o);

    assert_req_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_req_o |-> busy_o);

    assert_res_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> $stable(res_o));

    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o);
endmodule

bind osavg_ctrl osavg_chk #(.NCH(NCH), .DW(DW)) i_osavg_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_req_o (smp_req_o),
    .smp_vld_i (smp_vld_i),
    .busy_o    (busy_o),
    .res_o     (res_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/test_osavg_ctrl.sv
module test_osavg_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int GW  = 8;
    localparam int VW  = NCH * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnv_a = 1'b0, cnv_b = 1'b0;
    logic [2:0]    ratio_sel = 3'b000;
    logic [GW-1:0] gap = '0;
    logic          smp_req, smp_vld = 1'b0;
    logic [VW-1:0] smp_data = '0;
    logic          busy, cfg_err;
    logic [VW-1:0] res;

    always #2 clk = ~clk;

    osavg_ctrl #(.NCH(NCH), .DW(DW), .GAP_W(GW), .MAX_SHIFT(6)) i_osavg_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cnv_a_i(cnv_a), .cnv_b_i(cnv_b),
        .ratio_sel_i(ratio_sel), .gap_cycles_i(gap), .smp_req_o(smp_req),
        .smp_vld_i(smp_vld), .smp_data_i(smp_data), .busy_o(busy),
        .res_o(res), .cfg_err_o(cfg_err)
    );

    typedef struct { logic [VW-1:0] res; int n; } exp_t;
    exp_t exp_q[$];

    int total = 0, bad = 0;
    int conv_id = 0, cur_mode = 0, samp_k = 0, req_cnt = 0, cur_n = 1;
    logic [VW-1:0] last_res = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] smp(input int mode, input int cv, input int k, input int ch);
        int v;
        if (mode == 1) return 16'h8000;
        if (mode == 2) return 16'h7fff;
        v = (cv * 7919 + k * 613 + ch * 2711 + k * k * 37) % 65536;
        return v[15:0];
    endfunction

    function automatic int ratio_of(input logic [2:0] code);
        return (code == 3'b111) ? 1 : (1 << code);
    endfunction

    // Converter core model and gap measurement (R3, R8)
    initial begin
        forever begin
            @(negedge clk);
            while (smp_req && !done) begin
                int lat, low;
                req_cnt++;
                lat = 1 + (samp_k % 3);
                repeat (lat) @(negedge clk);
                smp_vld = 1'b1;
                for (int ch = 0; ch < NCH; ch++)
                    smp_data[ch*DW +: DW] = smp(cur_mode, conv_id, samp_k, ch);
                samp_k++;
                @(negedge clk);
                smp_vld = 1'b0;
                low = 0;
                while (!smp_req && busy && low < 1000) begin
                    low++;
                    @(negedge clk);
                end
                if (smp_req) chk(low == int'(gap) + 1, "R3 gap", low, int'(gap) + 1);
                else         chk(low == 1, "R8 busy fall", low, 1);
            end
        end
    end

    // Scoreboard monitor (R4, R6, R7)
    initial begin
        logic prev_busy;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev_busy && !busy) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected result", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    chk(req_cnt == e.n, "R4 request count", req_cnt, e.n);
                    chk(res == e.res, "R6 average", res, e.res);
                end
                last_res = res;
                req_cnt  = 0;
            end else if (rst_n && busy) begin
                if (res != last_res) chk(0, "R7 hold", res, last_res);
            end
            prev_busy = busy;
        end
    end

    task automatic conv(input logic [2:0] next_code, input int mode, input int g, input bit retrig);
        exp_t e;
        logic [2:0] decoy;
        gap = GW'(g);
        cur_mode = mode;
        conv_id++;
        samp_k = 0;
        e.n = cur_n;
        for (int ch = 0; ch < NCH; ch++) begin
            longint sum, qq;
            sum = 0;
            for (int k = 0; k < cur_n; k++) sum += longint'($signed(smp(mode, conv_id, k, ch)));
            qq = sum / cur_n;
            if ((sum % cur_n) != 0 && sum < 0) qq--;
            e.res[ch*DW +: DW] = qq[15:0];
        end
        exp_q.push_back(e);
        decoy = (next_code == 3'b001) ? 3'b010 : 3'b001;
        @(negedge clk);
        ratio_sel = decoy;
        cnv_a = 1'b1; cnv_b = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy rise", busy, 1);
        chk(smp_req == 1'b1, "R2 first request", smp_req, 1);
        @(negedge clk);
        ratio_sel = next_code;
        cnv_a = 1'b0; cnv_b = 1'b0;
        if (retrig) begin
            repeat (2) @(negedge clk);
            cnv_a = 1'b1; cnv_b = 1'b1;
            @(negedge clk);
            cnv_a = 1'b0; cnv_b = 1'b0;
        end
        while (busy) @(negedge clk);
        cur_n = ratio_of(next_code);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10 no queued burst", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(smp_req == 1'b0, "R1 req", smp_req, 0);
        chk(res == '0, "R1 res", res, 0);
        chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);

        // R2: one input alone is not a trigger
        cnv_a = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R2 single input", busy, 0);
        cnv_a = 1'b0;
        @(negedge clk);

        conv(3'b001, 0, 0, 0);   // N=1
        conv(3'b010, 0, 3, 0);   // N=2 (R5: decoy ignored)
        conv(3'b110, 0, 1, 1);   // N=4, re-trigger (R10)
        conv(3'b110, 1, 0, 0);   // N=64 full negative (R6)
        conv(3'b011, 2, 2, 0);   // N=64 full positive (R6)
        conv(3'b111, 0, 2, 0);   // N=8
        chk(cfg_err == 1'b1, "R9 err set", cfg_err, 1);
        conv(3'b100, 0, 0, 0);   // N=1 from invalid (R9)
        chk(cfg_err == 1'b1, "R9 err sticky", cfg_err, 1);
        conv(3'b101, 0, 5, 0);   // N=16
        conv(3'b000, 3, 1, 0);   // N=32
        conv(3'b000, 0, 0, 0);   // N=1
        chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule